// File: doc/BRIEF.md
# Audio Interrupt and Doorbell Hub

This block gathers the interrupt requests of an audio subsystem and presents them to two processors at once. Three serial audio port controllers each give one request line. A parameterised set of DMA channels each give a line of their own. All of these lines are sampled into one shared status vector. Two register views read that vector: one for the embedded audio DSP core and one for the host CPU. Each view has its own enable mask and its own aggregated, registered interrupt output. The host output goes to an I/O interrupt controller.

The block also carries two 32-bit message registers that act as doorbells between the processors. When the host writes its outbound message, a sticky pending flag is set and the DSP interrupt is raised. The DSP reads the word, then acknowledges by writing 1 to bit 0 of its bell register. In the other direction, a DSP write to its outbound message sets a pending flag. That flag drives a dedicated host line, `host_bell_irq`, which is separate from the host's peripheral line.

Each side has a plain register bus: a 3-bit word address, a write strobe, write data, and read data registered one cycle after the address. Word addresses are the same on both sides:

| Address | Register | Access |
|---------|----------|--------|
| 0 | status | read-only |
| 1 | mask | read/write |
| 2 | inbox | read-only |
| 3 | outbox | write rings the peer |
| 4 | bell | see R7 |

On reads of the bell register, bit 0 is the inbound pending flag and bit 1 is the outbound pending flag.

Top module: `audio_irq_hub`

## Requirements
- R1: Status bit i (serial ports at bits 0..2, DMA channel k at bit 3+k) equals the source line sampled at the previous clock edge, and both sides read the same status value at address 0.
- R2: `dsp_irq` is high exactly when, one cycle earlier, some status bit ANDed with the DSP mask was set or the host-to-DSP pending flag was set.
- R3: `host_periph_irq` is high exactly when, one cycle earlier, some status bit ANDed with the host mask was set.
- R4: A write to one side's mask (address 1) leaves the other side's mask and that other side's interrupt output unchanged.
- R5: A host write to address 3 stores the 32-bit word, and the DSP reads it at its address 2. The same write sets the host-to-DSP pending flag.
- R6: A DSP write to address 3 stores the word, and the host reads it at its address 2. The same write sets the DSP-to-host pending flag, which drives `host_bell_irq` one cycle later.
- R7: The receiving side clears its inbound pending flag by writing a value with bit 0 set to address 4. If the sender rings in the same cycle, the flag stays set.
- R8: A write to a side's inbox address (2) does not change the message stored there.
- R9: After reset, both masks are 0, both pending flags are 0, both messages are 0 and all interrupt outputs are low.
- R10: Read data presents the addressed register one clock after the address is applied. Unused upper bits read as 0.
- R11: `host_bell_irq` does not depend on the host mask and never drives `host_periph_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_irq | input | NUM_PORTS | Serial audio port request lines |
| dma_irq | input | NUM_DMA | One request line per DMA channel |
| dsp_addr | input | 3 | DSP word address |
| dsp_we | input | 1 | DSP write strobe |
| dsp_wdata | input | DATA_W | DSP write data |
| dsp_rdata | output | DATA_W | DSP read data, registered |
| host_addr | input | 3 | Host word address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, registered |
| dsp_irq | output | 1 | DSP interrupt: masked peripherals or host doorbell |
| host_periph_irq | output | 1 | Host masked peripheral interrupt |
| host_bell_irq | output | 1 | Dedicated DSP-to-host doorbell line |

## Verification
A wrong mask or status bit shows on the matching interrupt output two edges after a source changes, and on read data one edge after the address is applied. A pending flag that sticks or drops shows on `dsp_irq` or `host_bell_irq` in the cycle after the ring or clear, and at bell register bits 0 and 1. A reference model is compared with every output on every cycle, so any divergence in state is reported within one or two cycles of the stimulus that exposes it.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] A_MASK   = 3'd1;
  localparam logic [REG_AW-1:0] A_INBOX  = 3'd2;
  localparam logic [REG_AW-1:0] A_OUTBOX = 3'd3;
  localparam logic [REG_AW-1:0] A_BELL   = 3'd4;

  // Bit positions inside the bell register
  localparam int BELL_IN_BIT  = 0;
  localparam int BELL_OUT_BIT = 1;
endpackage

// File: rtl/irq_view.sv
// One processor's view: enable mask plus registered aggregate line.
module irq_view #(
  parameter int SRC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] status,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_wdata,
  input  logic             extra_irq,
  output logic [SRC_W-1:0] mask_q,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= (|(status & mask_q)) | extra_irq;
    end
  end
endmodule

// File: rtl/bell_mbox.sv
// Message word with a sticky doorbell flag; ring has priority over clear.
module bell_mbox #(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ring,
  input  logic [MSG_W-1:0] ring_data,
  input  logic             ack,
  output logic [MSG_W-1:0] msg_q,
  output logic             pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ring) begin
        msg_q  <= ring_data;
        pend_q <= 1'b1;
      end else if (ack) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/reg_port.sv
// Registered read mux for one side's register window.
module reg_port
  import audio_irq_pkg::*;
#(
  parameter int SRC_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic [SRC_W-1:0]  status,
  input  logic [SRC_W-1:0]  mask,
  input  logic [DATA_W-1:0] inbox,
  input  logic [DATA_W-1:0] outbox,
  input  logic              in_pend,
  input  logic              out_pend,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int PAD_W = DATA_W - SRC_W;

  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] bell_word;

  always_comb begin
    bell_word = '0;
    bell_word[BELL_IN_BIT]  = in_pend;
    bell_word[BELL_OUT_BIT] = out_pend;
  end

  always_comb begin
    case (addr)
      A_STATUS: rd_next = {{PAD_W{1'b0}}, status};
      A_MASK:   rd_next = {{PAD_W{1'b0}}, mask};
      A_INBOX:  rd_next = inbox;
      A_OUTBOX: rd_next = outbox;
      A_BELL:   rd_next = bell_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end
endmodule

// File: rtl/audio_irq_hub.sv
module audio_irq_hub
  import audio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int NUM_DMA   = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] port_irq,
  input  logic [NUM_DMA-1:0]   dma_irq,
  input  logic [REG_AW-1:0]    dsp_addr,
  input  logic                 dsp_we,
  input  logic [DATA_W-1:0]    dsp_wdata,
  output logic [DATA_W-1:0]    dsp_rdata,
  input  logic [REG_AW-1:0]    host_addr,
  input  logic                 host_we,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 dsp_irq,
  output logic                 host_periph_irq,
  output logic                 host_bell_irq
);
  localparam int SRC_W = NUM_PORTS + NUM_DMA;

  logic [SRC_W-1:0]  src_cat;
  logic [SRC_W-1:0]  status_q;
  logic [SRC_W-1:0]  dsp_mask, host_mask;
  logic [DATA_W-1:0] h2d_msg, d2h_msg;
  logic              h2d_pend, d2h_pend;
  logic              host_bell_q;

  // Source concatenation: ports first, then DMA channels
  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    assign src_cat[gp] = port_irq[gp];
  end
  for (genvar gd = 0; gd < NUM_DMA; gd++) begin : g_dma
    assign src_cat[NUM_PORTS+gd] = dma_irq[gd];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q    <= '0;
      host_bell_q <= 1'b0;
    end else begin
      status_q    <= src_cat;
      host_bell_q <= d2h_pend;
    end
  end

  logic host_ring, dsp_ring, dsp_ack, host_ack;
  assign host_ring = host_we && (host_addr == A_OUTBOX);
  assign dsp_ring  = dsp_we  && (dsp_addr  == A_OUTBOX);
  assign dsp_ack   = dsp_we  && (dsp_addr  == A_BELL) && dsp_wdata[BELL_IN_BIT];
  assign host_ack  = host_we && (host_addr == A_BELL) && host_wdata[BELL_IN_BIT];

  irq_view #(.SRC_W(SRC_W)) u_dsp_view (
    .clk(clk), .rst(rst), .status(status_q),
    .mask_we(dsp_we && (dsp_addr == A_MASK)),
    .mask_wdata(dsp_wdata[SRC_W-1:0]),
    .extra_irq(h2d_pend),
    .mask_q(dsp_mask), .irq_q(dsp_irq)
  );

  irq_view #(.SRC_W(SRC_W)) u_host_view (
    .clk(clk), .rst(rst), .status(status_q),
    .mask_we(host_we && (host_addr == A_MASK)),
    .mask_wdata(host_wdata[SRC_W-1:0]),
    .extra_irq(1'b0),
    .mask_q(host_mask), .irq_q(host_periph_irq)
  );

  bell_mbox #(.MSG_W(DATA_W)) u_h2d (
    .clk(clk), .rst(rst), .ring(host_ring), .ring_data(host_wdata),
    .ack(dsp_ack), .msg_q(h2d_msg), .pend_q(h2d_pend)
  );

  bell_mbox #(.MSG_W(DATA_W)) u_d2h (
    .clk(clk), .rst(rst), .ring(dsp_ring), .ring_data(dsp_wdata),
    .ack(host_ack), .msg_q(d2h_msg), .pend_q(d2h_pend)
  );

  reg_port #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_dsp_port (
    .clk(clk), .rst(rst), .addr(dsp_addr), .status(status_q),
    .mask(dsp_mask), .inbox(h2d_msg), .outbox(d2h_msg),
    .in_pend(h2d_pend), .out_pend(d2h_pend), .rdata_q(dsp_rdata)
  );

  reg_port #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_host_port (
    .clk(clk), .rst(rst), .addr(host_addr), .status(status_q),
    .mask(host_mask), .inbox(d2h_msg), .outbox(h2d_msg),
    .in_pend(d2h_pend), .out_pend(h2d_pend), .rdata_q(host_rdata)
  );

  assign host_bell_irq = host_bell_q;
endmodule

// File: rtl/audio_irq_hub_chk.sv
module audio_irq_hub_chk #(
  parameter int SRC_W  = 11,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        dsp_addr,
  input logic              dsp_we,
  input logic [DATA_W-1:0] dsp_wdata,
  input logic [2:0]        host_addr,
  input logic              host_we,
  input logic [SRC_W-1:0]  host_mask,
  input logic [DATA_W-1:0] h2d_msg,
  input logic              h2d_pend,
  input logic              d2h_pend,
  input logic              dsp_irq,
  input logic              host_periph_irq,
  input logic              host_bell_irq
);
  logic h_ring, d_ring, d_ack;
  assign h_ring = host_we && (host_addr == 3'd3);
  assign d_ring = dsp_we && (dsp_addr == 3'd3);
  assign d_ack  = dsp_we && (dsp_addr == 3'd4) && dsp_wdata[0];

  p_ring_sets_r5: assert property (@(posedge clk) disable iff (rst)
    h_ring |=> h2d_pend);

  p_ring_sets_r6: assert property (@(posedge clk) disable iff (rst)
    d_ring |=> d2h_pend);

  p_bell_line_r6: assert property (@(posedge clk) disable iff (rst)
    d2h_pend |=> host_bell_irq);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (d_ack && !h_ring) |=> !h2d_pend);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (d_ack && h_ring) |=> h2d_pend);

  p_inbox_ro_r8: assert property (@(posedge clk) disable iff (rst)
    (dsp_we && dsp_addr == 3'd2 && !h_ring) |=> $stable(h2d_msg));

  p_mask_iso_r4: assert property (@(posedge clk) disable iff (rst)
    (dsp_we && dsp_addr == 3'd1 && !(host_we && host_addr == 3'd1)) |=> $stable(host_mask));

  p_periph_off_r3: assert property (@(posedge clk) disable iff (rst)
    (host_mask == '0) |=> !host_periph_irq);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!dsp_irq && !host_periph_irq && !host_bell_irq && !h2d_pend && !d2h_pend));
endmodule

bind audio_irq_hub audio_irq_hub_chk #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
  .host_addr(host_addr), .host_we(host_we), .host_mask(host_mask),
  .h2d_msg(h2d_msg), .h2d_pend(h2d_pend), .d2h_pend(d2h_pend),
  .dsp_irq(dsp_irq), .host_periph_irq(host_periph_irq), .host_bell_irq(host_bell_irq)
);

// File: tb/audio_irq_hub_bench.sv
module audio_irq_hub_bench;
  localparam int NP = 3;
  localparam int ND = 8;
  localparam int SW = NP + ND;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] port_irq = '0;
  logic [ND-1:0] dma_irq = '0;
  logic [2:0] dsp_addr = '0, host_addr = '0;
  logic dsp_we = 1'b0, host_we = 1'b0;
  logic [DW-1:0] dsp_wdata = '0, host_wdata = '0;
  logic [DW-1:0] dsp_rdata, host_rdata;
  logic dsp_irq, host_periph_irq, host_bell_irq;

  int n_tests = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  audio_irq_hub u_audio_irq_hub (
    .clk(clk), .rst(rst), .port_irq(port_irq), .dma_irq(dma_irq),
    .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dsp_irq(dsp_irq), .host_periph_irq(host_periph_irq), .host_bell_irq(host_bell_irq)
  );

  // Reference model state
  logic [SW-1:0] m_stat, m_dmask, m_hmask;
  logic [DW-1:0] m_h2d, m_d2h, m_drd, m_hrd;
  bit m_hp, m_dp, m_dirq, m_hpirq, m_hbell;

  function automatic logic [DW-1:0] model_read(bit host_side, logic [2:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      3'd0: v[SW-1:0] = m_stat;
      3'd1: v[SW-1:0] = host_side ? m_hmask : m_dmask;
      3'd2: v = host_side ? m_d2h : m_h2d;
      3'd3: v = host_side ? m_h2d : m_d2h;
      3'd4: begin
        v[0] = host_side ? m_dp : m_hp;
        v[1] = host_side ? m_hp : m_dp;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat = '0; m_dmask = '0; m_hmask = '0; m_h2d = '0; m_d2h = '0;
      m_drd = '0; m_hrd = '0; m_hp = 0; m_dp = 0; m_dirq = 0; m_hpirq = 0; m_hbell = 0;
    end else begin
      logic [DW-1:0] nd, nh;
      bit h_ring, d_ring, d_ack, h_ack;
      nd = model_read(0, dsp_addr);
      nh = model_read(1, host_addr);
      m_dirq  = (|(m_stat & m_dmask)) || m_hp;
      m_hpirq = |(m_stat & m_hmask);
      m_hbell = m_dp;
      h_ring = host_we && host_addr == 3'd3;
      d_ring = dsp_we && dsp_addr == 3'd3;
      d_ack  = dsp_we && dsp_addr == 3'd4 && dsp_wdata[0];
      h_ack  = host_we && host_addr == 3'd4 && host_wdata[0];
      if (dsp_we && dsp_addr == 3'd1) m_dmask = dsp_wdata[SW-1:0];
      if (host_we && host_addr == 3'd1) m_hmask = host_wdata[SW-1:0];
      if (h_ring) m_h2d = host_wdata;
      if (d_ring) m_d2h = dsp_wdata;
      m_hp = h_ring ? 1'b1 : (d_ack ? 1'b0 : m_hp);
      m_dp = d_ring ? 1'b1 : (h_ack ? 1'b0 : m_dp);
      m_stat = {dma_irq, port_irq};
      m_drd = nd;
      m_hrd = nh;
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 dsp_irq", {31'b0, dsp_irq}, {31'b0, m_dirq});
      chk("R3 host_periph_irq", {31'b0, host_periph_irq}, {31'b0, m_hpirq});
      chk("R6 host_bell_irq", {31'b0, host_bell_irq}, {31'b0, m_hbell});
      chk("R10 dsp_rdata", dsp_rdata, m_drd);
      chk("R10 host_rdata", host_rdata, m_hrd);
    end
  end

  task automatic dsp_wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk); dsp_addr = a; dsp_wdata = d; dsp_we = 1'b1;
    @(negedge clk); dsp_we = 1'b0;
  endtask

  task automatic host_wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic dsp_rd(logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); dsp_addr = a;
    @(negedge clk); d = dsp_rdata;
  endtask

  task automatic host_rd(logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    idle(3);
    // R9: outputs during reset
    chk("R9 reset dsp_irq", {31'b0, dsp_irq}, 32'd0);
    chk("R9 reset host lines", {30'b0, host_periph_irq, host_bell_irq}, 32'd0);
    rst = 1'b0;
    cmp_on = 1'b1;
    host_rd(3'd1, rd); chk("R9 host mask", rd, 32'd0);
    dsp_rd(3'd2, rd);  chk("R9 dsp inbox", rd, 32'd0);
    dsp_rd(3'd4, rd);  chk("R9 dsp bell", rd, 32'd0);

    // R1/R2/R4: port 1 active, DSP enables it only
    port_irq = 3'b010;
    dsp_wr(3'd1, 32'h0000_0002);
    idle(2);
    chk("R2 dsp_irq on masked source", {31'b0, dsp_irq}, 32'd1);
    chk("R4 host line unaffected", {31'b0, host_periph_irq}, 32'd0);
    host_rd(3'd1, rd); chk("R4 host mask unchanged", rd, 32'd0);

    // R3: DMA channel 5 -> bit 8, host enables it
    dma_irq = 8'h20;
    host_wr(3'd1, 32'h0000_0100);
    idle(2);
    chk("R3 host_periph_irq", {31'b0, host_periph_irq}, 32'd1);
    dsp_rd(3'd1, rd); chk("R4 dsp mask unchanged", rd, 32'h2);
    dsp_rd(3'd0, rd);  chk("R1 dsp status", rd, 32'h0000_0102);
    host_rd(3'd0, rd); chk("R1 host status", rd, 32'h0000_0102);

    // R5/R8/R7: host-to-DSP doorbell
    port_irq = '0; dma_irq = '0;
    idle(3);
    chk("R2 dsp_irq low after source drop", {31'b0, dsp_irq}, 32'd0);
    host_wr(3'd3, 32'hCAFE_0001);
    idle(1);
    chk("R5 doorbell raises dsp_irq", {31'b0, dsp_irq}, 32'd1);
    dsp_rd(3'd2, rd); chk("R5 dsp inbox", rd, 32'hCAFE_0001);
    dsp_wr(3'd2, 32'h1234_5678);
    dsp_rd(3'd2, rd); chk("R8 inbox write ignored", rd, 32'hCAFE_0001);
    dsp_wr(3'd4, 32'h1);
    dsp_rd(3'd4, rd); chk("R7 ack clears pending", rd, 32'h0);
    idle(1);
    chk("R7 dsp_irq low after ack", {31'b0, dsp_irq}, 32'd0);

    // R7: ring and ack in the same cycle
    @(negedge clk);
    host_addr = 3'd3; host_wdata = 32'hBEEF_0002; host_we = 1'b1;
    dsp_addr = 3'd4; dsp_wdata = 32'h1; dsp_we = 1'b1;
    @(negedge clk); host_we = 1'b0; dsp_we = 1'b0;
    dsp_rd(3'd4, rd); chk("R7 set wins race", rd, 32'h1);
    dsp_wr(3'd4, 32'h1);

    // R6/R11: DSP-to-host doorbell, host mask cleared
    host_wr(3'd1, 32'h0);
    dma_irq = 8'hFF;
    dsp_wr(3'd3, 32'h55AA_33CC);
    idle(1);
    chk("R6 host_bell_irq set", {31'b0, host_bell_irq}, 32'd1);
    chk("R11 periph line stays low", {31'b0, host_periph_irq}, 32'd0);
    host_rd(3'd2, rd); chk("R6 host inbox", rd, 32'h55AA_33CC);
    host_rd(3'd4, rd); chk("R6 host bell bit0", rd, 32'h1);
    host_wr(3'd4, 32'h1);
    idle(1);
    chk("R7 host ack drops bell line", {31'b0, host_bell_irq}, 32'd0);

    // Random traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      port_irq = NP'($urandom);
      dma_irq  = ND'($urandom);
      dsp_addr = 3'($urandom % 6);
      host_addr = 3'($urandom % 6);
      dsp_we  = ($urandom % 4) == 0;
      host_we = ($urandom % 4) == 0;
      dsp_wdata = $urandom;
      host_wdata = $urandom;
    end
    @(negedge clk); dsp_we = 1'b0; host_we = 1'b0;
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule